// File: doc/BRIEF.md
# Masked Interrupt Factor Controller

This block gathers six interrupt sources for a small 4-bit microcontroller and turns them into one request to the CPU. The sources are two groups of four key pins, three clock-timer taps (slow, medium and fast) and a strobe from the remote-control logic. Each source has its own factor flag. A falling edge on a key pin or timer tap sets the flag, and so does a strobe on the remote input. Software reads a flag register to learn which sources fired, and that read empties the register.

Every source also has an enable bit. A request goes to the CPU only when some flag is set, its enable bit is set and the global interrupt-enable is on. The block offers a vector made of a fixed page nibble and a step chosen by priority. When the CPU acknowledges, the global enable drops and the vector is frozen for the length of the CPU's entry sequence. A separate wake output ignores the global enable, so that a halted CPU can resume.

Top module: `irqf_ctrl`

## Requirements
- R1: A falling edge on any one of the four pins of a key group, or on a timer tap, sets that source's flag after a two-stage synchronizer. A rising edge sets nothing.
- R2: A cycle with `rem_evt_i` high sets the remote flag at that clock edge.
- R3: Register map at base 0xF0. 0xF0 holds the flags in bit0 = key group 0, bit1 = key group 1 and bit2 = remote. 0xF1 holds the flags in bit0 = fast tap, bit1 = medium tap and bit2 = slow tap. 0xF2 and 0xF3 hold the enable bits in the same bit positions. Bit3 always reads 0. Writes to 0xF0 and 0xF1 are ignored. Reads of unmapped addresses return 0. Read data appears on `bus_rdata_o` in the cycle after the read strobe.
- R4: A read of a flag register returns the flag values from before the read and clears every flag in that register. The other flag register is unchanged.
- R5: If a source event and a read-clear of its flag fall in the same cycle, the flag is 1 afterwards.
- R6: After reset, all flags, all enables, the global enable, `irq_o`, `wake_o` and `entry_busy_o` are 0.
- R7: `irq_o` is a registered copy of (any flag AND its enable) AND global enable. It is held low while `entry_busy_o` is high.
- R8: `irq_vec_o` is {4'h1, step}. The step is 0x2 for key group 0, 0x4 for key group 1, 0x6 for remote, 0x8 for the fast tap, 0xA for the medium tap and 0xC for the slow tap. The lowest step among enabled, pending sources wins. The step is 0x0 when none are pending.
- R9: `irq_ack_i` while `irq_o` is high clears the global enable, and `irq_o` is low in the next cycle. An acknowledge while `irq_o` is low has no effect.
- R10: An accepted acknowledge raises `entry_busy_o` for exactly ENTRY_CYCLES (12) cycles. During that time `irq_vec_o` does not change.
- R11: `wake_o` is a registered copy of (any flag AND its enable) and does not depend on the global enable.
- R12: `gie_set_i` sets the global enable and `gie_clr_i` clears it. Clear wins over set, and an accepted acknowledge wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key0_i | input | 4 | Key group 0 pins, asynchronous |
| key1_i | input | 4 | Key group 1 pins, asynchronous |
| tmr_slow_i | input | 1 | Slow timer tap, asynchronous |
| tmr_mid_i | input | 1 | Medium timer tap, asynchronous |
| tmr_fast_i | input | 1 | Fast timer tap, asynchronous |
| rem_evt_i | input | 1 | Remote-control event strobe, synchronous |
| bus_addr_i | input | 8 | Register address |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 4 | Write data |
| bus_rdata_o | output | 4 | Registered read data |
| gie_set_i | input | 1 | Set global interrupt enable |
| gie_clr_i | input | 1 | Clear global interrupt enable |
| irq_ack_i | input | 1 | CPU accepts the interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 8 | Page and step of the vector |
| gie_o | output | 1 | Global interrupt enable state |
| entry_busy_o | output | 1 | CPU entry sequence in progress |
| wake_o | output | 1 | Release from halt |

## Verification
The assertions check several rules on every cycle. A flag never drops without a read of its register, and an event always leaves its flag set. The priority grant is one-hot. An accepted acknowledge removes both the request and the global enable. The vector holds still and no request appears during the entry window. Only the bench's scenarios can show the rest: the exact register bit positions, that a rising edge sets nothing, the step value for each source and combination, the twelve-cycle length of the entry window, and the same-cycle race between an event and a read.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int NSRC = 6;

  typedef enum logic [2:0] {
    SRC_KEY0 = 3'd0,
    SRC_KEY1 = 3'd1,
    SRC_REM  = 3'd2,
    SRC_FAST = 3'd3,
    SRC_MID  = 3'd4,
    SRC_SLOW = 3'd5
  } src_e;

  localparam logic [3:0] VEC_PAGE = 4'h1;

  // lower source index -> lower step -> higher priority
  function automatic logic [3:0] step_of(input int idx);
    return 4'((idx + 1) * 2);
  endfunction
endpackage

// File: rtl/irqf_fall_det.sv
module irqf_fall_det #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] sync_q [STAGES];
  logic [W-1:0] prev_q;

  // reset to low so an idle-high pin never looks like a fall after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
  parameter int             NSRC = 6,
  parameter int             FPR  = 3,
  parameter int             DW   = 4,
  parameter int             AW   = 8,
  parameter logic [AW-1:0]  BASE = 8'hF0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            rd_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NSRC-1:0] flags_o,
  output logic [NSRC-1:0] mask_o
);
  localparam int NREG = (NSRC + FPR - 1) / FPR;

  logic [AW-1:0]   off;
  logic            hit, rd_hit, wr_hit;
  logic [NSRC-1:0] flags_q, mask_q, clr;
  logic [DW-1:0]   rsel, rdata_q;
  logic            unused_wbits;

  assign off    = addr_i - BASE;
  assign hit    = (addr_i >= BASE) && (off < AW'(2 * NREG));
  assign rd_hit = rd_i && hit;
  assign wr_hit = wr_i && hit;
  assign unused_wbits = ^wdata_i;

  always_comb begin
    clr  = '0;
    rsel = '0;
    for (int i = 0; i < NSRC; i++) begin
      clr[i] = rd_hit && (off == AW'(i / FPR));
      if (off == AW'(i / FPR))        rsel[i % FPR] = flags_q[i];
      if (off == AW'(NREG + i / FPR)) rsel[i % FPR] = mask_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      // a new event beats a read-clear in the same cycle
      flags_q <= (flags_q & ~clr) | set_i;
      for (int i = 0; i < NSRC; i++)
        if (wr_hit && (off == AW'(NREG + i / FPR))) mask_q[i] <= wdata_i[i % FPR];
      rdata_q <= rd_hit ? rsel : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign flags_o = flags_q;
  assign mask_o  = mask_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R5: an event always leaves the flag set
    a_r5_event_wins: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> flags_q[g]);
    // R4: a flag only drops through a read of its own register
    a_r4_hold_until_read: assert property (@(posedge clk) disable iff (rst)
      (flags_q[g] && !clr[g]) |=> flags_q[g]);
  end
endmodule

// File: rtl/irqf_prio_enc.sv
module irqf_prio_enc
  import irqf_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o,
  output logic [3:0]   step_o
);
  always_comb begin
    grant_o = '0;
    step_o  = 4'h0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        step_o     = step_of(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
  import irqf_pkg::*;
#(
  parameter int             KEYW         = 4,
  parameter int             AW           = 8,
  parameter logic [AW-1:0]  BASE         = 8'hF0,
  parameter int             ENTRY_CYCLES = 12,
  parameter int             SYNC_STAGES  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [KEYW-1:0] key0_i,
  input  logic [KEYW-1:0] key1_i,
  input  logic            tmr_slow_i,
  input  logic            tmr_mid_i,
  input  logic            tmr_fast_i,
  input  logic            rem_evt_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            bus_rd_i,
  input  logic            bus_wr_i,
  input  logic [3:0]      bus_wdata_i,
  output logic [3:0]      bus_rdata_o,
  input  logic            gie_set_i,
  input  logic            gie_clr_i,
  input  logic            irq_ack_i,
  output logic            irq_o,
  output logic [7:0]      irq_vec_o,
  output logic            gie_o,
  output logic            entry_busy_o,
  output logic            wake_o
);
  localparam int PW    = 2 * KEYW + 3;
  localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);

  logic [PW-1:0]    pins, falls;
  logic [NSRC-1:0]  set, flags, mask, enabled, grant;
  logic             pend, ack_ok, busy;
  logic [3:0]       step;
  logic [CNT_W-1:0] cnt_q;
  logic             gie_q, irq_q, wake_q;
  logic [7:0]       vec_q;

  assign pins = {tmr_slow_i, tmr_mid_i, tmr_fast_i, key1_i, key0_i};

  irqf_fall_det #(.W(PW), .STAGES(SYNC_STAGES)) u_fall (
    .clk(clk), .rst(rst), .pin_i(pins), .fall_o(falls)
  );

  always_comb begin
    set           = '0;
    set[SRC_KEY0] = |falls[KEYW-1:0];
    set[SRC_KEY1] = |falls[2*KEYW-1:KEYW];
    set[SRC_REM]  = rem_evt_i;
    set[SRC_FAST] = falls[2*KEYW];
    set[SRC_MID]  = falls[2*KEYW+1];
    set[SRC_SLOW] = falls[2*KEYW+2];
  end

  irqf_flag_bank #(.NSRC(NSRC), .FPR(3), .DW(4), .AW(AW), .BASE(BASE)) u_bank (
    .clk(clk), .rst(rst), .set_i(set),
    .addr_i(bus_addr_i), .rd_i(bus_rd_i), .wr_i(bus_wr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
    .flags_o(flags), .mask_o(mask)
  );

  assign enabled = flags & mask;

  irqf_prio_enc #(.N(NSRC)) u_prio (
    .req_i(enabled), .grant_o(grant), .any_o(pend), .step_o(step)
  );

  assign busy   = (cnt_q != '0);
  assign ack_ok = irq_ack_i && irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
      cnt_q  <= '0;
      vec_q  <= {VEC_PAGE, 4'h0};
    end else begin
      if (ack_ok)         gie_q <= 1'b0;
      else if (gie_clr_i) gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;

      if (ack_ok)    cnt_q <= CNT_W'(ENTRY_CYCLES);
      else if (busy) cnt_q <= cnt_q - 1'b1;

      irq_q  <= pend && gie_q && !busy && !ack_ok;
      wake_q <= pend;
      if (!busy && !ack_ok) vec_q <= {VEC_PAGE, step};
    end
  end

  assign irq_o        = irq_q;
  assign irq_vec_o    = vec_q;
  assign gie_o        = gie_q;
  assign entry_busy_o = busy;
  assign wake_o       = wake_q;

  // R9: accepted acknowledge removes request and global enable
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && irq_o) |=> (!gie_o && !irq_o));
  // R7: a request is only raised from an enabled global state
  a_r7_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(gie_q));
  // R10: vector frozen while the CPU runs its entry sequence
  a_r10_vec_frozen: assert property (@(posedge clk) disable iff (rst)
    entry_busy_o |-> $stable(irq_vec_o));
  // R10: no request issued during the entry window
  a_r10_no_irq_in_entry: assert property (@(posedge clk) disable iff (rst)
    entry_busy_o |=> !irq_o);
  // R8: at most one source granted
  a_r8_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: tb/irqf_ctrl_tb.sv
module irqf_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] key0 = 4'hF, key1 = 4'hF;
  logic       t_slow = 1'b1, t_mid = 1'b1, t_fast = 1'b1, rem = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd_s = 1'b0, wr_s = 1'b0;
  logic [3:0] wdata = 4'h0;
  logic [3:0] rdata;
  logic       gset = 1'b0, gclr = 1'b0, ack = 1'b0;
  logic       irq, gie, busy, wake;
  logic [7:0] vec;

  int checks = 0;
  int errors = 0;
  int busy_cycles = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irqf_ctrl u_dut (
    .clk(clk), .rst(rst), .key0_i(key0), .key1_i(key1),
    .tmr_slow_i(t_slow), .tmr_mid_i(t_mid), .tmr_fast_i(t_fast),
    .rem_evt_i(rem), .bus_addr_i(addr), .bus_rd_i(rd_s), .bus_wr_i(wr_s),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .gie_set_i(gset),
    .gie_clr_i(gclr), .irq_ack_i(ack), .irq_o(irq), .irq_vec_o(vec),
    .gie_o(gie), .entry_busy_o(busy), .wake_o(wake)
  );

  always @(negedge clk) if (busy) busy_cycles++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [3:0] d);
    addr = a; rd_s = 1'b1;
    @(negedge clk);
    rd_s = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] d);
    addr = a; wdata = d; wr_s = 1'b1;
    @(negedge clk);
    wr_s = 1'b0;
  endtask

  task automatic pulse_gie(input logic s, input logic c);
    gset = s; gclr = c;
    @(negedge clk);
    gset = 1'b0; gclr = 1'b0;
  endtask

  // src bits: 0 key0, 1 key1, 2 remote, 3 fast, 4 mid, 5 slow
  task automatic fire(input logic [5:0] src, input int pin);
    if (src[0]) key0[pin] = 1'b0;
    if (src[1]) key1[pin] = 1'b0;
    rem = src[2];
    if (src[3]) t_fast = 1'b0;
    if (src[4]) t_mid  = 1'b0;
    if (src[5]) t_slow = 1'b0;
    @(negedge clk);
    rem = 1'b0;
    @(negedge clk);
    key0 = 4'hF; key1 = 4'hF; t_fast = 1'b1; t_mid = 1'b1; t_slow = 1'b1;
    cyc_wait(6);
  endtask

  task automatic clear_all();
    logic [3:0] d;
    rd(8'hF0, d);
    rd(8'hF1, d);
    cyc_wait(2);
  endtask

  function automatic int exp_vec(input logic [5:0] en);
    for (int i = 0; i < 6; i++) if (en[i]) return 8'h10 | ((i + 1) * 2);
    return 8'h10;
  endfunction

  initial begin
    logic [3:0] d;
    logic [5:0] sb;
    cyc_wait(5);
    rst = 1'b0;
    cyc_wait(2);

    // R6 reset state
    chk("R6 irq", irq, 0); chk("R6 wake", wake, 0);
    chk("R6 gie", gie, 0); chk("R6 busy", busy, 0);
    for (int a = 0; a < 4; a++) begin
      rd(8'hF0 + 8'(a), d);
      chk("R6 reg", d, 0);
    end

    // R3 register map behaviour
    wr(8'hF2, 4'hF); rd(8'hF2, d); chk("R3 bit3 reads 0", d, 7);
    wr(8'hF3, 4'h5); rd(8'hF3, d); chk("R3 enable readback", d, 5);
    wr(8'hF0, 4'hF); rd(8'hF0, d); chk("R3 flag write ignored", d, 0);
    wr(8'hF1, 4'hF); rd(8'hF1, d); chk("R3 flag write ignored", d, 0);
    rd(8'hF4, d); chk("R3 unmapped read", d, 0);
    rd(8'hEF, d); chk("R3 unmapped read", d, 0);
    wr(8'hF2, 4'h0); wr(8'hF3, 4'h0);

    // R1 rising edge ignored
    key0 = 4'h0; key1 = 4'h0; t_fast = 1'b0; t_mid = 1'b0; t_slow = 1'b0;
    cyc_wait(6);
    clear_all();
    key0 = 4'hF; key1 = 4'hF; t_fast = 1'b1; t_mid = 1'b1; t_slow = 1'b1;
    cyc_wait(6);
    rd(8'hF0, d); chk("R1 rising ignored", d, 0);
    rd(8'hF1, d); chk("R1 rising ignored", d, 0);

    // per-source sweep: R1 R2 R3 R4 R7 R8 R11 R12
    for (int s = 0; s < 6; s++) begin
      for (int p = 0; p < 4; p++) begin
        if (s < 2 || p == 0) begin
          fire(6'(1 << s), p);
          chk("R11 masked no wake", wake, 0);
          rd(8'hF0 + 8'(s / 3), d); chk("R1 R2 flag position", d, 1 << (s % 3));
          rd(8'hF1 - 8'(s / 3), d); chk("R3 other reg empty", d, 0);
          rd(8'hF0 + 8'(s / 3), d); chk("R4 cleared by read", d, 0);
        end
      end
      wr(8'hF2 + 8'(s / 3), 4'(1 << (s % 3)));
      fire(6'(1 << s), s % 4);
      chk("R11 wake without gie", wake, 1);
      chk("R7 no irq without gie", irq, 0);
      chk("R8 vector step", vec, exp_vec(6'(1 << s)));
      pulse_gie(1'b1, 1'b0);
      cyc_wait(1);
      chk("R7 irq with gie", irq, 1);
      pulse_gie(1'b0, 1'b1);
      cyc_wait(1);
      chk("R12 clear gie", gie, 0);
      chk("R7 irq drops", irq, 0);
      clear_all();
      chk("R11 wake drops", wake, 0);
      wr(8'hF2, 4'h0); wr(8'hF3, 4'h0);
    end

    // priority sweep over all combinations: R8 R3 R4 R1
    wr(8'hF2, 4'h7); wr(8'hF3, 4'h7);
    for (int c = 1; c < 64; c++) begin
      sb = 6'(c);
      fire(sb, c % 4);
      chk("R8 priority vector", vec, exp_vec(sb));
      chk("R11 wake", wake, 1);
      rd(8'hF0, d); chk("R3 R4 low flags", d, {1'b0, sb[2:0]});
      rd(8'hF1, d); chk("R3 R4 high flags", d, {1'b0, sb[5:3]});
      cyc_wait(2);
      chk("R8 idle vector", vec, 8'h10);
    end

    // R8 only enabled sources compete
    wr(8'hF2, 4'h6);
    fire(6'b100001, 0);
    chk("R8 masked source skipped", vec, 8'h1C);
    clear_all();

    // R5 event and read-clear in the same cycle
    addr = 8'hF0; rd_s = 1'b1; rem = 1'b1;
    @(negedge clk);
    rd_s = 1'b0; rem = 1'b0;
    chk("R5 read shows old value", rdata, 0);
    rd(8'hF0, d); chk("R5 event wins", d, 4);

    // R4 read of one register leaves the other
    fire(6'b001001, 1);
    rd(8'hF0, d); chk("R4 low reg", d, 1);
    rd(8'hF1, d); chk("R4 high reg untouched", d, 1);

    // R9 R10 acknowledge and entry window
    wr(8'hF2, 4'h5); wr(8'hF3, 4'h0);
    pulse_gie(1'b1, 1'b0);
    fire(6'b000100, 0);
    chk("R7 irq remote", irq, 1);
    chk("R8 remote vector", vec, 8'h16);
    busy_cycles = 0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R9 gie cleared", gie, 0);
    chk("R9 irq dropped", irq, 0);
    chk("R10 busy", busy, 1);
    pulse_gie(1'b1, 1'b0);
    fire(6'b000001, 2);
    chk("R10 vector frozen", vec, 8'h16);
    chk("R10 irq held low", irq, 0);
    for (int w = 0; w < 30 && busy; w++) @(negedge clk);
    cyc_wait(2);
    chk("R10 window length", busy_cycles, 12);
    chk("R8 vector after window", vec, 8'h12);
    chk("R7 irq after window", irq, 1);

    // R9 ack without a request is ignored
    clear_all();
    chk("R7 irq gone", irq, 0);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    cyc_wait(1);
    chk("R9 stray ack gie", gie, 1);
    chk("R9 stray ack busy", busy, 0);

    // R12 clear wins over set
    pulse_gie(1'b1, 1'b1);
    cyc_wait(1);
    chk("R12 clear wins", gie, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule